// File: doc/BRIEF.md
# Two-Register Serial Port

This block is an asynchronous serial transmitter and receiver that a small 8-bit processor reaches through two byte-wide registers. One select input chooses the register. With the select low, the processor reaches the byte register. A write there launches a frame on the `tx` line. A read there returns the byte most recently accepted from `rx`. With the select high, the processor reaches the status register. A read there reports whether the transmitter is still shifting and whether a received byte is waiting. A write there, whatever its value, marks the waiting byte as taken.

The block runs from its own fast clock, which is independent of the processor clock. It divides that clock down to the bit period set by `CLKS_PER_BIT`. The default of 1250 gives 9600 baud from 12 MHz. Frames are 8N1: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The receiver synchronises the line, detects the start bit on a falling edge and confirms it half a bit later. It then samples each later bit at its centre.

Top module: `uart_regs`

## Requirements
- R1: After reset, `tx` is high, the status register reads 0x00 and the byte register reads 0x00.
- R2: A byte-register write (`sel`=0) while the transmitter is idle sets the busy status bit at the next clock edge. From that same edge, `tx` drives a low start bit for `CLKS_PER_BIT` clocks.
- R3: After the start bit, `tx` carries the written byte least significant bit first, one bit per `CLKS_PER_BIT` clocks, then a high stop bit. Busy clears exactly 10×`CLKS_PER_BIT` clocks after the write edge, and `tx` then stays high.
- R4: A byte-register write while busy is set is ignored: the frame in flight carries the original byte and its timing is unchanged.
- R5: With `sel`=1, `rdata` returns the status register: bit 0 is transmitter busy, bit 1 is receive-full, and bits 7:2 read 0. With `sel`=0, `rdata` returns the received byte.
- R6: A valid frame on `rx` places its byte in the byte register and sets receive-full.
- R7: A status-register write (`sel`=1) of any value clears receive-full. It leaves the received byte readable. If a frame completes in the same cycle, receive-full is set instead.
- R8: A low pulse on `rx` that has ended before half a bit period passes is dropped. It leaves receive-full and the byte register unchanged, and the next valid frame is received normally.
- R9: A frame whose stop bit is low is discarded: receive-full and the byte register keep their previous values.
- R10: A valid frame that arrives while receive-full is set overwrites the byte register, and receive-full stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one clock per access |
| sel | input | 1 | Register select: 0 byte register, 1 status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| tx | output | 1 | Serial output, idles high |
| rx | input | 1 | Serial input, asynchronous |

## Verification
The assertions check on every cycle the properties that hold locally. A write launches a start bit. Busy only rises because of an accepted write. The line is high whenever the transmitter is idle. Receive-full only falls after a status write and otherwise holds. The status register's upper bits are zero. Only the bench's scenarios can show the serial behaviour over whole frames. These scenarios cover bit order and bit timing on `tx`, mid-bit sampling on `rx`, rejection of start glitches and bad stop bits, overrun replacement of the stored byte, and a write that arrives while a frame is in flight.

// File: rtl/uart_regs.sv
module uart_regs #(
  parameter int CLKS_PER_BIT = 1250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       tx,
  input  logic       rx
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  logic [9:0]    tx_sh;
  logic [3:0]    tx_idx;
  logic [CW-1:0] tx_cnt;
  logic          tx_busy;

  logic          rx_s1, rx_s2, rx_s3;
  rx_st_t        rx_st;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_idx;
  logic [7:0]    rx_sh;
  logic [7:0]    rx_data;
  logic          rx_full;

  wire tx_go   = wr_en & ~sel & ~tx_busy;
  wire rx_done = (rx_st == RX_STOP) && (rx_cnt == BIT_LAST) && rx_s2;

  assign tx    = tx_sh[0];
  assign rdata = sel ? {6'b0, rx_full, tx_busy} : rx_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '1;
      tx_idx  <= '0;
      tx_cnt  <= '0;
      tx_busy <= 1'b0;
    end else if (tx_go) begin
      tx_sh   <= {1'b1, wdata, 1'b0};
      tx_idx  <= '0;
      tx_cnt  <= '0;
      tx_busy <= 1'b1;
    end else if (tx_busy) begin
      if (tx_cnt == BIT_LAST) begin
        tx_cnt <= '0;
        tx_sh  <= {1'b1, tx_sh[9:1]};
        tx_idx <= tx_idx + 4'd1;
        if (tx_idx == 4'd9) tx_busy <= 1'b0;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_s3   <= 1'b1;
      rx_st   <= RX_IDLE;
      rx_cnt  <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
    end else begin
      rx_s1 <= rx;
      rx_s2 <= rx_s1;
      rx_s3 <= rx_s2;
      case (rx_st)
        RX_IDLE:
          if (rx_s3 && !rx_s2) begin
            rx_st  <= RX_START;
            rx_cnt <= '0;
          end
        RX_START:
          if (rx_cnt == HALF_LAST) begin
            rx_cnt <= '0;
            rx_idx <= '0;
            rx_st  <= rx_s2 ? RX_IDLE : RX_DATA;
          end else begin
            rx_cnt <= rx_cnt + 1'b1;
          end
        RX_DATA:
          if (rx_cnt == BIT_LAST) begin
            rx_cnt <= '0;
            rx_sh  <= {rx_s2, rx_sh[7:1]};
            rx_idx <= rx_idx + 3'd1;
            if (rx_idx == 3'd7) rx_st <= RX_STOP;
          end else begin
            rx_cnt <= rx_cnt + 1'b1;
          end
        RX_STOP:
          if (rx_cnt == BIT_LAST) begin
            rx_cnt <= '0;
            rx_st  <= RX_IDLE;
          end else begin
            rx_cnt <= rx_cnt + 1'b1;
          end
        default: rx_st <= RX_IDLE;
      endcase
      if (rx_done) begin
        rx_data <= rx_sh;
        rx_full <= 1'b1;
      end else if (wr_en && sel) begin
        rx_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       sel,
  input logic [7:0] rdata,
  input logic       tx,
  input logic       busy,
  input logic       full
);
  assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);

  assert_launch_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel && !busy) |=> (busy && !tx));

  assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && !sel && !busy));

  assert_status_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    sel |-> (rdata[7:2] == 6'b0));

  assert_clear_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(full) |-> $past(wr_en && sel));

  assert_full_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (full && !(wr_en && sel)) |=> full);
endmodule

bind uart_regs uart_regs_chk i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .rdata(rdata),
  .tx(tx), .busy(tx_busy), .full(rx_full)
);

// File: tb/test_uart_regs.sv
module test_uart_regs;
  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tx;
  logic       rx = 1'b1;

  int vectors = 0;
  int errs = 0;
  logic       m_full = 1'b0;
  logic [7:0] m_data = 8'h00;

  always #5 clk = ~clk;

  uart_regs #(.CLKS_PER_BIT(CPB)) i_uart_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .rdata(rdata), .tx(tx), .rx(rx)
  );

  function automatic logic exp_tx(input logic [7:0] b, input int c);
    int k = c / CPB;
    if (k == 0) return 1'b0;
    if (k >= 9) return 1'b1;
    return b[k-1];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    sel = s;
    #1 v = rdata;
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_regs(input string req);
    logic [7:0] v;
    rd(1'b1, v); chk(req, v & 8'h02, {6'b0, m_full, 1'b0});
    rd(1'b0, v); chk(req, v, m_data);
  endtask

  task automatic tx_frame(input logic [7:0] b, input logic poke);
    logic [7:0] v;
    wr(1'b0, b);
    rd(1'b1, v); chk("R2 busy after write", v & 8'h01, 8'h01);
    for (int c = 0; c < 10 * CPB; c++) begin
      if (c % CPB == CPB / 2)
        chk(poke ? "R4 frame under busy write" : "R3 tx bit", {7'b0, tx}, {7'b0, exp_tx(b, c)});
      if (c == 0) chk("R2 start bit", {7'b0, tx}, 8'h00);
      if (c == 10 * CPB - 1) begin
        rd(1'b1, v); chk("R3 busy through stop", v & 8'h01, 8'h01);
      end
      if (poke && c == 3) begin
        wr_en = 1'b1; sel = 1'b0; wdata = ~b;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    rd(1'b1, v); chk("R3 busy cleared", v & 8'h01, 8'h00);
    chk("R3 idle high", {7'b0, tx}, 8'h01);
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop_ok);
    for (int k = 0; k < 10; k++) begin
      rx = (k == 0) ? 1'b0 : (k == 9) ? stop_ok : b[k-1];
      repeat (CPB) @(negedge clk);
    end
    rx = 1'b1;
    repeat (CPB) @(negedge clk);
    if (stop_ok) begin
      m_data = b;
      m_full = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] b;
    void'($urandom(32'h0000_5eed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R1 tx idle", {7'b0, tx}, 8'h01);
    rd(1'b1, v); chk("R1 status", v, 8'h00);
    rd(1'b0, v); chk("R1 data", v, 8'h00);

    tx_frame(8'hA5, 1'b0);
    tx_frame(8'h01, 1'b1);

    rx_frame(8'h3C, 1'b1);
    check_regs("R6 receive");
    rd(1'b1, v); chk("R5 status layout", v, 8'h02);

    wr(1'b1, 8'h00);
    m_full = 1'b0;
    check_regs("R7 clear keeps data");

    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (2 * CPB) @(negedge clk);
    check_regs("R8 glitch ignored");
    rx_frame(8'hC3, 1'b1);
    check_regs("R8 next frame after glitch");

    rx_frame(8'h96, 1'b1);
    check_regs("R10 overrun");

    rx_frame(8'h5A, 1'b0);
    repeat (CPB) @(negedge clk);
    check_regs("R9 bad stop");
    wr(1'b1, 8'hFF);
    m_full = 1'b0;
    rx_frame(8'h77, 1'b0);
    repeat (CPB) @(negedge clk);
    check_regs("R9 bad stop empty");

    for (int i = 0; i < 10; i++) begin
      b = 8'($urandom);
      case ($urandom % 3)
        0: tx_frame(b, i[0]);
        1: begin rx_frame(b, 1'b1); check_regs("R6 random receive"); end
        default: begin
          wr(1'b1, b);
          m_full = 1'b0;
          check_regs("R7 random clear");
        end
      endcase
      rd(1'b1, v); chk("R5 status random", v, {6'b0, m_full, 1'b0});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule